// File: doc/BRIEF.md
# Extended-to-IEEE Precision Converter

This block narrows a floating-point value held in a wide internal form into a standard single-precision or double-precision word. The source is a sign, a 15-bit biased exponent and a 64-bit mantissa whose integer bit is stored explicitly, so the value may arrive unnormalized. The block renormalizes the mantissa, moves the exponent onto the destination bias and rounds to the destination precision under one of four rounding modes. It then checks the rounded result against the narrower exponent range and reports overflow, underflow and inexact.

A producer offers one operand per cycle with a valid/ready handshake. Each operand carries its own destination-format select and rounding-mode select. The result appears one cycle after acceptance, together with its exception flags. It is held until the consumer takes it. Single-precision results sit in the low 32 bits of a 64-bit word, and the upper half is zero.

Top module: `xr_narrow_conv`

## Requirements
- R1: An operand is accepted on a rising edge where `in_valid` and `in_ready` are both high, and its result is shown with `out_valid` high after that edge. `in_ready` is high whenever no result is pending or `out_ready` is high. A pending result stays unchanged while `out_ready` is low.
- R2: With `in_fmt` = 0 the result is single precision: sign in bit 31, 8-bit exponent field (bias 127) in bits 30:23, 23-bit fraction in bits 22:0. Bits 63:32 are zero.
- R3: With `in_fmt` = 1 the result is double precision: sign in bit 63, 11-bit exponent field (bias 1023) in bits 62:52, 52-bit fraction in bits 51:0.
- R4: A finite nonzero source has the value mantissa × 2^(e − 16383 − 63), where e is the exponent field, or 1 when the field is 0. The source is normalized whatever its integer bit is, and its exponent is rebiased to the destination.
- R5: `in_rmode` selects the rounding: 0 to nearest with ties to even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity. The rounding decision uses the first discarded bit and the OR of all lower discarded bits.
- R6: When rounding carries out of the fraction, the exponent field goes up by one and the fraction becomes zero.
- R7: When the rounded exponent field would reach all ones, `out_ovf` and `out_inx` are raised. The result is the largest finite magnitude for toward-zero, for toward-minus-infinity on a positive value and for toward-plus-infinity on a negative value. In every other case it is infinity.
- R8: A result below the smallest normal magnitude is denormalized before rounding, with every shifted-out bit kept in the sticky term. It may round to a signed zero or up to the smallest normal. `out_unf` is raised when the rounded exponent field is 0 and the result is inexact.
- R9: A source exponent of all ones with zero fraction bits below the integer bit gives an infinity of the same sign, with no flags. With nonzero fraction bits it gives a quiet NaN: fraction MSB set, the next fraction bits copied from source mantissa bits 61 downward, and no flags.
- R10: A zero mantissa with a source exponent that is not all ones gives a zero of the same sign, with no flags.
- R11: `out_inx` is raised whenever any discarded bit is nonzero, including when only the lowest discarded bits are set.
- R12: While `rst_n` is low, `out_valid`, the flags and `out_word` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be accepted this cycle |
| in_sign | input | 1 | Source sign |
| in_exp | input | 15 | Source biased exponent |
| in_man | input | 64 | Source mantissa with explicit integer bit |
| in_fmt | input | 1 | Destination select: 0 single, 1 double |
| in_rmode | input | 2 | Rounding mode select |
| out_valid | output | 1 | Result pending |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 64 | Packed result, zero-extended for single |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |

## Verification
The conversion is tried on the following patterns, each chosen to separate one behaviour from its neighbours:
- exact values in both formats, and an unnormalized source, which separate rebiasing from normalization;
- halfway and sticky-only mantissas under all four rounding modes, which tell tie-to-even apart from plain round-half-up and show that low discarded bits reach the sticky term;
- an all-ones mantissa, which forces a carry into the exponent, both inside the range and across the overflow boundary;
- overflowing, tiny and extended-denormal sources, which show how the mode and sign choose between infinity and the largest finite value, and how a tiny result flushes to zero or rounds up to the smallest normal.

Directed sequences cover back-pressure, where a pending result must hold while a new operand waits, and the reset state.

// File: rtl/xrconv_pkg.sv
package xrconv_pkg;

  localparam int SRC_EXP_W  = 15;
  localparam int SRC_MAN_W  = 64;
  localparam int SRC_BIAS   = (1 << (SRC_EXP_W - 1)) - 1;

  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;

  localparam int SGL_BIAS   = (1 << (SGL_EXP_W - 1)) - 1;
  localparam int DBL_BIAS   = (1 << (DBL_EXP_W - 1)) - 1;
  localparam int SGL_EMAX   = (1 << SGL_EXP_W) - 1;
  localparam int DBL_EMAX   = (1 << DBL_EXP_W) - 1;
  localparam int SGL_W      = 1 + SGL_EXP_W + SGL_FRAC_W;
  localparam int WORD_W     = 1 + DBL_EXP_W + DBL_FRAC_W;

  localparam int MAX_P      = DBL_FRAC_W + 1;
  localparam int SH_CAP     = SRC_MAN_W + 2;
  localparam int SH_W       = $clog2(SH_CAP + 1);
  localparam int VEC_W      = SRC_MAN_W + SH_CAP;
  localparam int EXPW       = SRC_EXP_W + 3;
  localparam int LZ_W       = $clog2(SRC_MAN_W + 1);

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_DOWN    = 2'd2,
    RM_UP      = 2'd3
  } rmode_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic inx;
  } xflags_t;

  // Number of leading zeros; SRC_MAN_W for an all-zero mantissa.
  function automatic logic [LZ_W-1:0] count_lz(input logic [SRC_MAN_W-1:0] m);
    logic [LZ_W-1:0] n;
    n = LZ_W'(SRC_MAN_W);
    for (int i = 0; i < SRC_MAN_W; i++) begin
      if (m[i]) n = LZ_W'(SRC_MAN_W - 1 - i);
    end
    return n;
  endfunction

  // Increment decision from kept LSB, first dropped bit and sticky OR.
  function automatic logic round_inc(input rmode_e rm, input logic sign,
                                     input logic lsb, input logic g,
                                     input logic rest);
    case (rm)
      RM_NEAREST: return g & (rest | lsb);
      RM_ZERO:    return 1'b0;
      RM_DOWN:    return sign & (g | rest);
      default:    return ~sign & (g | rest);
    endcase
  endfunction

  // Overflow saturates to the largest finite value instead of infinity.
  function automatic logic ovf_to_max(input rmode_e rm, input logic sign);
    return (rm == RM_ZERO) || (rm == RM_DOWN && !sign) || (rm == RM_UP && sign);
  endfunction

endpackage

// File: rtl/xr_classify.sv
module xr_classify
  import xrconv_pkg::*;
(
  input  logic [SRC_EXP_W-1:0]   exp_i,
  input  logic [SRC_MAN_W-1:0]   man_i,
  output logic                   is_inf_o,
  output logic                   is_nan_o,
  output logic                   is_zero_o,
  output logic [SRC_MAN_W-1:0]   norm_o,
  output logic [EXPW-1:0]        unb_exp_o
);

  logic                 exp_max;
  logic                 frac_nz;
  logic [LZ_W-1:0]      lz;
  logic [SRC_EXP_W-1:0] exp_eff;

  assign exp_max   = &exp_i;
  assign frac_nz   = |man_i[SRC_MAN_W-2:0];
  assign is_inf_o  = exp_max & ~frac_nz;
  assign is_nan_o  = exp_max & frac_nz;
  assign is_zero_o = ~exp_max & ~(|man_i);

  assign lz      = count_lz(man_i);
  assign norm_o  = man_i << lz;
  assign exp_eff = (exp_i == '0) ? SRC_EXP_W'(1) : exp_i;

  // Two's-complement unbiased exponent of the normalized value.
  assign unb_exp_o = EXPW'(exp_eff) - EXPW'(lz) - EXPW'(SRC_BIAS);

endmodule

// File: rtl/xr_round_pack.sv
module xr_round_pack
  import xrconv_pkg::*;
(
  input  logic                 sign_i,
  input  logic [SRC_MAN_W-1:0] norm_i,
  input  logic [EXPW-1:0]      unb_exp_i,
  input  logic                 fmt_i,
  input  rmode_e               rm_i,
  output logic [WORD_W-1:0]    word_o,
  output xflags_t              flags_o,
  output logic                 ev_carry_o,
  output logic                 ev_tiny_o,
  output logic                 ev_ovf_o
);

  int                p;
  int                bias;
  int                emax;
  logic [EXPW-1:0]   be;
  logic [EXPW-1:0]   sh_full;
  logic [SH_W-1:0]   sh;
  logic              tiny;
  logic [VEC_W-1:0]  vec;
  logic [VEC_W-1:0]  rmask;
  logic [MAX_P-1:0]  kept;
  logic [MAX_P-1:0]  fmask;
  logic [MAX_P-1:0]  frac;
  logic [MAX_P:0]    m2;
  logic              g, rest, inc, carry, lead;
  logic [EXPW-1:0]   base, field, field_o;
  logic              ovf, inexact, sat;

  always_comb begin
    p    = fmt_i ? DBL_FRAC_W + 1 : SGL_FRAC_W + 1;
    bias = fmt_i ? DBL_BIAS : SGL_BIAS;
    emax = fmt_i ? DBL_EMAX : SGL_EMAX;

    be   = unb_exp_i + EXPW'(bias);
    tiny = be[EXPW-1] | (be == '0);

    sh_full = EXPW'(1) - be;
    if (!tiny)                        sh = '0;
    else if (sh_full > EXPW'(SH_CAP)) sh = SH_W'(SH_CAP);
    else                              sh = sh_full[SH_W-1:0];

    vec   = {norm_i, {SH_CAP{1'b0}}} >> sh;
    kept  = MAX_P'(vec >> (VEC_W - p));
    g     = vec[VEC_W - 1 - p];
    rmask = (VEC_W'(1) << (VEC_W - 1 - p)) - VEC_W'(1);
    rest  = |(vec & rmask);

    inc   = round_inc(rm_i, sign_i, kept[0], g, rest);
    m2    = {1'b0, kept} + (MAX_P + 1)'(inc);
    carry = m2[p];
    lead  = m2[p - 1];

    base  = tiny ? '0 : be - EXPW'(1);
    field = base + EXPW'(lead) + (carry ? EXPW'(2) : '0);
    fmask = (MAX_P'(1) << (p - 1)) - MAX_P'(1);
    frac  = m2[MAX_P-1:0] & fmask;

    inexact = g | rest;
    ovf     = (field >= EXPW'(emax));
    sat     = ovf_to_max(rm_i, sign_i);

    field_o = field;
    if (ovf) begin
      field_o = sat ? EXPW'(emax - 1) : EXPW'(emax);
      frac    = sat ? fmask : '0;
    end

    flags_o.ovf = ovf;
    flags_o.inx = inexact | ovf;
    flags_o.unf = ~ovf & (field == '0) & inexact;

    if (fmt_i)
      word_o = {sign_i, field_o[DBL_EXP_W-1:0], frac[DBL_FRAC_W-1:0]};
    else
      word_o = {{(WORD_W - SGL_W){1'b0}}, sign_i,
                field_o[SGL_EXP_W-1:0], frac[SGL_FRAC_W-1:0]};
  end

  assign ev_carry_o = carry;
  assign ev_tiny_o  = tiny;
  assign ev_ovf_o   = ovf;

endmodule

// File: rtl/xr_hold_reg.sv
module xr_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  input  logic         take_i,
  output logic         can_load_o,
  output logic         valid_o,
  output logic [W-1:0] q_o
);

  assign can_load_o = ~valid_o | take_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      q_o     <= '0;
    end else if (load_i && can_load_o) begin
      valid_o <= 1'b1;
      q_o     <= d_i;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/xr_narrow_conv.sv
module xr_narrow_conv
  import xrconv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_sign,
  input  logic [SRC_EXP_W-1:0] in_exp,
  input  logic [SRC_MAN_W-1:0] in_man,
  input  logic                 in_fmt,
  input  logic [1:0]           in_rmode,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [WORD_W-1:0]    out_word,
  output logic                 out_ovf,
  output logic                 out_unf,
  output logic                 out_inx
);

  localparam int HOLD_W = 1 + 3 + WORD_W;

  logic                 is_inf, is_nan, is_zero;
  logic [SRC_MAN_W-1:0] norm;
  logic [EXPW-1:0]      unb_exp;
  logic [WORD_W-1:0]    rp_word, sp_word, res_word;
  xflags_t              rp_flags, res_flags;
  logic                 ev_carry, ev_tiny, ev_overflow;
  logic [HOLD_W-1:0]    hold_q;
  logic                 fmt_q;

  xr_classify u_cls (
    .exp_i     (in_exp),
    .man_i     (in_man),
    .is_inf_o  (is_inf),
    .is_nan_o  (is_nan),
    .is_zero_o (is_zero),
    .norm_o    (norm),
    .unb_exp_o (unb_exp)
  );

  xr_round_pack u_rnd (
    .sign_i     (in_sign),
    .norm_i     (norm),
    .unb_exp_i  (unb_exp),
    .fmt_i      (in_fmt),
    .rm_i       (rmode_e'(in_rmode)),
    .word_o     (rp_word),
    .flags_o    (rp_flags),
    .ev_carry_o (ev_carry),
    .ev_tiny_o  (ev_tiny),
    .ev_ovf_o   (ev_overflow)
  );

  // Special operands bypass the rounding path.
  always_comb begin
    sp_word = '0;
    if (in_fmt) begin
      if (is_inf)
        sp_word = {in_sign, {DBL_EXP_W{1'b1}}, {DBL_FRAC_W{1'b0}}};
      else if (is_nan)
        sp_word = {in_sign, {DBL_EXP_W{1'b1}}, 1'b1,
                   in_man[SRC_MAN_W-3 -: DBL_FRAC_W-1]};
      else
        sp_word = {in_sign, {(WORD_W-1){1'b0}}};
    end else begin
      if (is_inf)
        sp_word = {{(WORD_W-SGL_W){1'b0}}, in_sign, {SGL_EXP_W{1'b1}},
                   {SGL_FRAC_W{1'b0}}};
      else if (is_nan)
        sp_word = {{(WORD_W-SGL_W){1'b0}}, in_sign, {SGL_EXP_W{1'b1}}, 1'b1,
                   in_man[SRC_MAN_W-3 -: SGL_FRAC_W-1]};
      else
        sp_word = {{(WORD_W-SGL_W){1'b0}}, in_sign, {(SGL_W-1){1'b0}}};
    end
  end

  always_comb begin
    if (is_inf || is_nan || is_zero) begin
      res_word  = sp_word;
      res_flags = '0;
    end else begin
      res_word  = rp_word;
      res_flags = rp_flags;
    end
  end

  xr_hold_reg #(.W(HOLD_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (in_valid),
    .d_i        ({in_fmt, res_flags, res_word}),
    .take_i     (out_ready),
    .can_load_o (in_ready),
    .valid_o    (out_valid),
    .q_o        (hold_q)
  );

  assign fmt_q    = hold_q[HOLD_W-1];
  assign out_ovf  = hold_q[WORD_W+2];
  assign out_unf  = hold_q[WORD_W+1];
  assign out_inx  = hold_q[WORD_W];
  assign out_word = hold_q[WORD_W-1:0];

endmodule

// File: rtl/xr_narrow_conv_chk.sv
module xr_narrow_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_word,
  input logic        out_ovf,
  input logic        out_unf,
  input logic        out_inx,
  input logic        fmt_q,
  input logic        ev_tiny,
  input logic        ev_overflow
);

  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)
      && $stable(out_ovf) && $stable(out_unf) && $stable(out_inx));

  // R2
  zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !fmt_q |-> out_word[63:32] == 32'h0);

  // R7
  ovf_inx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |-> out_inx && !out_unf);

  // R7
  ovf_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ovf |->
      (fmt_q ? (&out_word[62:53]) : (&out_word[30:24])));

  // R8
  unf_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unf |->
      out_inx && (fmt_q ? (out_word[62:52] == '0) : (out_word[30:23] == '0)));

  // R8
  tiny_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tiny |-> !ev_overflow);

  // R12
  reset_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid && out_word == '0);

endmodule

bind xr_narrow_conv xr_narrow_conv_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_word    (out_word),
  .out_ovf     (out_ovf),
  .out_unf     (out_unf),
  .out_inx     (out_inx),
  .fmt_q       (fmt_q),
  .ev_tiny     (ev_tiny),
  .ev_overflow (ev_overflow)
);

// File: tb/test_xr_narrow_conv.sv
`timescale 1ns/1ps
module test_xr_narrow_conv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_sign = 1'b0;
  logic [14:0] in_exp = '0;
  logic [63:0] in_man = '0;
  logic        in_fmt = 1'b0;
  logic [1:0]  in_rmode = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_word;
  logic        out_ovf, out_unf, out_inx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  xr_narrow_conv i_xr_narrow_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_man(in_man), .in_fmt(in_fmt),
    .in_rmode(in_rmode), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_ovf(out_ovf), .out_unf(out_unf), .out_inx(out_inx)
  );

  // Vector: sign, exp, man, fmt, rmode, expected word, expected {ovf,unf,inx}
  localparam int NV = 34;
  localparam logic [149:0] VECS [NV] = '{
    {1'b0, 15'h3FFF, 64'h8000000000000000, 1'b0, 2'd0, 64'h3F800000, 3'b000},          // R2
    {1'b0, 15'h3FFF, 64'h8000000000000000, 1'b1, 2'd0, 64'h3FF0000000000000, 3'b000},  // R3
    {1'b1, 15'h4000, 64'hA000000000000000, 1'b1, 2'd0, 64'hC004000000000000, 3'b000},  // R3
    {1'b0, 15'h4000, 64'h4000000000000000, 1'b0, 2'd0, 64'h3F800000, 3'b000},          // R4
    {1'b0, 15'h4002, 64'hC000000000000000, 1'b0, 2'd0, 64'h41400000, 3'b000},          // R4
    {1'b0, 15'h3FFF, 64'h8000008000000000, 1'b0, 2'd0, 64'h3F800000, 3'b001},          // R5
    {1'b0, 15'h3FFF, 64'h8000008000000000, 1'b0, 2'd3, 64'h3F800001, 3'b001},          // R5
    {1'b0, 15'h3FFF, 64'h8000008000000000, 1'b0, 2'd1, 64'h3F800000, 3'b001},          // R5
    {1'b1, 15'h3FFF, 64'h8000008000000000, 1'b0, 2'd2, 64'hBF800001, 3'b001},          // R5
    {1'b0, 15'h3FFF, 64'h8000018000000000, 1'b0, 2'd0, 64'h3F800002, 3'b001},          // R5
    {1'b0, 15'h3FFF, 64'hFFFFFFFFFFFFFFFF, 1'b0, 2'd0, 64'h40000000, 3'b001},          // R6
    {1'b0, 15'h3FFF, 64'hFFFFFFFFFFFFFFFF, 1'b1, 2'd0, 64'h4000000000000000, 3'b001},  // R6
    {1'b0, 15'h407F, 64'h8000000000000000, 1'b0, 2'd0, 64'h7F800000, 3'b101},          // R7
    {1'b0, 15'h407F, 64'h8000000000000000, 1'b0, 2'd1, 64'h7F7FFFFF, 3'b101},          // R7
    {1'b1, 15'h407F, 64'h8000000000000000, 1'b0, 2'd3, 64'hFF7FFFFF, 3'b101},          // R7
    {1'b1, 15'h407F, 64'h8000000000000000, 1'b0, 2'd2, 64'hFF800000, 3'b101},          // R7
    {1'b0, 15'h407E, 64'hFFFFFFFFFFFFFFFF, 1'b0, 2'd0, 64'h7F800000, 3'b101},          // R7
    {1'b0, 15'h407E, 64'h8000000000000000, 1'b0, 2'd0, 64'h7F000000, 3'b000},          // R7
    {1'b0, 15'h3F6A, 64'h8000000000000000, 1'b0, 2'd0, 64'h00000001, 3'b000},          // R8
    {1'b0, 15'h3F69, 64'h8000000000000000, 1'b0, 2'd0, 64'h00000000, 3'b011},          // R8
    {1'b0, 15'h3F69, 64'h8000000000000000, 1'b0, 2'd3, 64'h00000001, 3'b011},          // R8
    {1'b1, 15'h3F69, 64'h8000000000000000, 1'b0, 2'd0, 64'h80000000, 3'b011},          // R8
    {1'b0, 15'h3F80, 64'hFFFFFFFFFFFFFFFF, 1'b0, 2'd0, 64'h00800000, 3'b001},          // R8
    {1'b0, 15'h3BCD, 64'h8000000000000000, 1'b1, 2'd0, 64'h0000000000000001, 3'b000},  // R8
    {1'b0, 15'h0000, 64'h4000000000000000, 1'b0, 2'd0, 64'h00000000, 3'b011},          // R8
    {1'b0, 15'h7FFF, 64'h8000000000000000, 1'b0, 2'd0, 64'h7F800000, 3'b000},          // R9
    {1'b1, 15'h7FFF, 64'h8000000000000000, 1'b1, 2'd0, 64'hFFF0000000000000, 3'b000},  // R9
    {1'b0, 15'h7FFF, 64'h9234567800000000, 1'b0, 2'd0, 64'h7FD23456, 3'b000},          // R9
    {1'b0, 15'h7FFF, 64'h8000000000000001, 1'b1, 2'd0, 64'h7FF8000000000000, 3'b000},  // R9
    {1'b1, 15'h0000, 64'h0000000000000000, 1'b1, 2'd0, 64'h8000000000000000, 3'b000},  // R10
    {1'b0, 15'h0000, 64'h0000000000000000, 1'b0, 2'd0, 64'h00000000, 3'b000},          // R10
    {1'b0, 15'h3FFF, 64'h8000000000000008, 1'b1, 2'd1, 64'h3FF0000000000000, 3'b001},  // R11
    {1'b0, 15'h3FFF, 64'h8000000000000008, 1'b1, 2'd3, 64'h3FF0000000000001, 3'b001},  // R11
    {1'b0, 15'h3FFF, 64'h8000000000000001, 1'b0, 2'd0, 64'h3F800000, 3'b001}           // R11
  };
  localparam int TAGS [NV] = '{2,3,3,4,4,5,5,5,5,5,6,6,7,7,7,7,7,7,
                               8,8,8,8,8,8,8,9,9,9,9,10,10,11,11,11};

  task automatic check(input bit ok, input string req,
                       input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [149:0] v);
    in_sign  = v[149];
    in_exp   = v[148:134];
    in_man   = v[133:70];
    in_fmt   = v[69];
    in_rmode = v[68:67];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready && out_word == '0 && !out_ovf && !out_unf && !out_inx,
          "R12", {out_ovf, out_unf, out_inx, out_word}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R12", {65'h0, out_valid, in_ready}, 67'h1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      in_valid  = 1'b1;
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid && {out_ovf, out_unf, out_inx, out_word} == {VECS[i][2:0], VECS[i][66:3]},
            $sformatf("R%0d vec%0d", TAGS[i], i),
            {out_ovf, out_unf, out_inx, out_word}, {VECS[i][2:0], VECS[i][66:3]});
    end

    // R1: back-pressure holds the pending result
    @(negedge clk);
    out_ready = 1'b0;
    drive(VECS[0]);
    in_valid = 1'b1;
    check(in_ready, "R1", {66'h0, in_ready}, 67'h1);
    @(negedge clk);
    check(out_valid && !in_ready && out_word == 64'h3F800000, "R1",
          {1'b0, out_valid, in_ready, out_word}, {3'b100, 64'h3F800000});
    drive(VECS[1]);
    @(negedge clk);
    check(out_valid && out_word == 64'h3F800000, "R1",
          {2'b0, out_valid, out_word}, {3'b001, 64'h3F800000});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_word == 64'h3FF0000000000000, "R1",
          {2'b0, out_valid, out_word}, {3'b001, 64'h3FF0000000000000});
    @(negedge clk);
    check(!out_valid && in_ready, "R1", {65'h0, out_valid, in_ready}, 67'h1);

    // R12: reset in mid-run clears a pending result
    out_ready = 1'b0;
    drive(VECS[2]);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(!out_valid && out_word == '0, "R12", {2'b0, out_valid, out_word}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule